// File: doc/BRIEF.md
# Handshake Link Message Framer

This block sits between byte-level logic and a two-wire, fully handshaken bit link on which either end may stall for any length of time. On the send side it takes bytes from a valid/ready stream and turns them into a bit stream for the link. Each message opens with a filler 1. Each byte then goes out as a 0 start bit followed by eight data bits, most significant bit first. A single 1 placed where the next start bit would go closes the message.

On the receive side it watches the bits the link delivers. It throws away 1 bits that arrive while it is waiting for a message to begin. It rebuilds each byte after its start bit and pulses an end strobe when a 1 follows a complete byte.

A message can be flagged as wanting an answer. In that case the block keeps the link turned towards the far side: it refuses new bytes until an incoming message has ended. The far side's first bit is its own leading 1, which is discarded as filler.

Back-pressure rules:
- The byte input is a valid/ready stream. A byte is taken on a clock edge where both `tx_valid` and `tx_ready` are high. The fields must stay stable while valid waits for ready.
- The bit output is a valid/ready stream. `tx_bit` stays stable while `tx_bit_valid` waits for `tx_bit_ready`.
- The receive bit input and the byte output carry no ready. The block takes one bit per cycle whenever `rx_bit_valid` is high and it is not sending.

Top module: `handshake_msg_framer`

## Requirements
- R1: Every message starts on the bit output with one 1 bit, sent before the first start bit.
- R2: Each byte goes out as a 0 start bit followed by its eight data bits, most significant first.
- R3: After the byte marked last, exactly one 1 bit is sent. When it is taken, `dir_tx` drops to 0 (receive).
- R4: While the block waits for the next byte of an unfinished message, `tx_ready` is 1, `tx_bit_valid` is 0 and `dir_tx` stays 1. The next byte then starts directly with its 0 start bit, with no filler 1 before it.
- R5: While `tx_bit_valid` is high and `tx_bit_ready` is low, `tx_bit_valid` and `tx_bit` hold their values.
- R6: 1 bits received while no message is in progress are discarded. After a 0 start bit, the next eight bits are assembled most significant first. The result appears on `rx_byte` with a one-cycle `rx_byte_valid` pulse.
- R7: A 1 received in the start-bit slot after a complete byte gives a one-cycle `rx_msg_end` pulse. Further 1 bits after it produce no output.
- R8: After a message sent with `tx_reply`=1 ends, `tx_ready` stays 0 until an incoming message ends with `rx_msg_end`. With `tx_reply`=0, `tx_ready` is 1 again as soon as the end bit is taken.
- R9: While an incoming message is in progress (from its start bit until its end marker), `tx_ready` is 0.
- R10: `dir_tx` is 1 from the cycle after the first byte of a message is taken until the end bit is taken. While it is 0, `tx_bit_valid` is 0.
- R11: After reset, `dir_tx`, `tx_bit_valid`, `rx_byte_valid` and `rx_msg_end` are 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Byte offered for sending |
| tx_ready | output | 1 | Byte can be taken |
| tx_data | input | 8 | Byte to send |
| tx_last | input | 1 | Byte closes the message |
| tx_reply | input | 1 | Message expects an answer (sampled with each byte; the last byte's value counts) |
| tx_bit_valid | output | 1 | Bit offered to the link |
| tx_bit_ready | input | 1 | Link takes the bit |
| tx_bit | output | 1 | Bit value to the link |
| rx_bit_valid | input | 1 | Bit delivered by the link |
| rx_bit | input | 1 | Delivered bit value |
| rx_byte_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| rx_msg_end | output | 1 | Received message ended |
| dir_tx | output | 1 | 1 while sending, 0 while receiving |

## Verification
A sender state that goes astray shows up on the very next accepted bit. The bit comes out with the wrong value, a filler 1 is missing or doubled, or the end 1 comes early. It can also show as `tx_ready` rising while `dir_tx` still reads 1 for a finished message. A receiver that loses its bit count produces a byte with shifted bits, a missing `rx_byte_valid`, or a spurious `rx_msg_end` within one byte time. A reply-wait flag that is wrong shows as soon as the send of a reply-flagged message finishes: `tx_ready` reads 1 when it should read 0.

// File: rtl/hlf_pkg.sv
package hlf_pkg;
  typedef enum logic [2:0] {
    TX_IDLE, TX_LEAD, TX_START, TX_DATA, TX_NEXT, TX_ENDM
  } tx_st_t;

  typedef enum logic [1:0] {
    RX_HUNT, RX_DATA, RX_GAP
  } rx_st_t;
endpackage

// File: rtl/hlf_tx.sv
module hlf_tx
  import hlf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         allow,
  input  logic         byte_valid,
  input  logic [W-1:0] byte_data,
  input  logic         byte_last,
  input  logic         byte_reply,
  output logic         byte_ready,
  output logic         bit_valid,
  output logic         bit_val,
  input  logic         bit_ready,
  output logic         busy,
  output logic         done,
  output logic         done_reply
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  tx_st_t       st;
  logic [W-1:0] sh;
  logic [CW-1:0] cnt;
  logic         last_q, reply_q;

  always_comb begin
    byte_ready = (st == TX_IDLE && allow) || st == TX_NEXT;
    bit_valid  = st == TX_LEAD || st == TX_START || st == TX_DATA || st == TX_ENDM;
    if (st == TX_START)     bit_val = 1'b0;
    else if (st == TX_DATA) bit_val = sh[W-1];
    else                    bit_val = 1'b1;
    busy       = st != TX_IDLE;
    done       = st == TX_ENDM && bit_ready;
    done_reply = reply_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TX_IDLE;
      sh      <= '0;
      cnt     <= '0;
      last_q  <= 1'b0;
      reply_q <= 1'b0;
    end else begin
      unique case (st)
        TX_IDLE: if (byte_valid && allow) begin
          sh <= byte_data; last_q <= byte_last; reply_q <= byte_reply;
          st <= TX_LEAD;
        end
        TX_NEXT: if (byte_valid) begin
          sh <= byte_data; last_q <= byte_last; reply_q <= byte_reply;
          st <= TX_START;
        end
        TX_LEAD:  if (bit_ready) st <= TX_START;
        TX_START: if (bit_ready) begin
          st  <= TX_DATA;
          cnt <= CW'(W - 1);
        end
        TX_DATA: if (bit_ready) begin
          sh <= sh << 1;
          if (cnt == '0) st <= last_q ? TX_ENDM : TX_NEXT;
          else           cnt <= cnt - 1'b1;
        end
        TX_ENDM: if (bit_ready) st <= TX_IDLE;
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hlf_rx.sv
module hlf_rx
  import hlf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         bit_valid,
  input  logic         bit_val,
  output logic         byte_valid,
  output logic [W-1:0] byte_data,
  output logic         msg_end,
  output logic         busy
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  rx_st_t        st;
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          take;

  assign take = en && bit_valid;
  assign busy = st != RX_HUNT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_HUNT;
      sh         <= '0;
      cnt        <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      msg_end    <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      msg_end    <= 1'b0;
      if (take) begin
        unique case (st)
          RX_HUNT: if (!bit_val) begin
            st  <= RX_DATA;
            cnt <= '0;
          end
          RX_DATA: begin
            sh <= {sh[W-2:0], bit_val};
            if (cnt == CW'(W - 1)) begin
              byte_valid <= 1'b1;
              byte_data  <= {sh[W-2:0], bit_val};
              st         <= RX_GAP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_GAP: begin
            if (bit_val) begin
              msg_end <= 1'b1;
              st      <= RX_HUNT;
            end else begin
              st  <= RX_DATA;
              cnt <= '0;
            end
          end
          default: st <= RX_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/handshake_msg_framer.sv
module handshake_msg_framer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  input  logic         tx_last,
  input  logic         tx_reply,
  output logic         tx_bit_valid,
  input  logic         tx_bit_ready,
  output logic         tx_bit,
  input  logic         rx_bit_valid,
  input  logic         rx_bit,
  output logic         rx_byte_valid,
  output logic [W-1:0] rx_byte,
  output logic         rx_msg_end,
  output logic         dir_tx
);
  logic tx_busy, tx_done, tx_done_reply;
  logic rx_busy;
  logic reply_wait;
  logic allow;

  assign allow  = !reply_wait && !rx_busy;
  assign dir_tx = tx_busy;

  hlf_tx #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .allow(allow),
    .byte_valid(tx_valid), .byte_data(tx_data), .byte_last(tx_last),
    .byte_reply(tx_reply), .byte_ready(tx_ready),
    .bit_valid(tx_bit_valid), .bit_val(tx_bit), .bit_ready(tx_bit_ready),
    .busy(tx_busy), .done(tx_done), .done_reply(tx_done_reply)
  );

  hlf_rx #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(!tx_busy),
    .bit_valid(rx_bit_valid), .bit_val(rx_bit),
    .byte_valid(rx_byte_valid), .byte_data(rx_byte),
    .msg_end(rx_msg_end), .busy(rx_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       reply_wait <= 1'b0;
    else if (tx_done && tx_done_reply) reply_wait <= 1'b1;
    else if (rx_msg_end)              reply_wait <= 1'b0;
  end
endmodule

// File: rtl/handshake_msg_framer_chk.sv
module handshake_msg_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic dir_tx,
  input logic tx_bit_valid,
  input logic tx_bit_ready,
  input logic tx_bit,
  input logic rx_byte_valid,
  input logic rx_msg_end
);
  AST_NO_BIT_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_tx |-> !tx_bit_valid); // R10
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit_valid && !tx_bit_ready |=> tx_bit_valid && $stable(tx_bit)); // R5
  AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_tx) |-> tx_bit_valid && tx_bit); // R1
  AST_END_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir_tx) |-> $past(tx_bit_valid && tx_bit_ready && tx_bit)); // R3
  AST_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_byte_valid, rx_msg_end})); // R7
endmodule

bind handshake_msg_framer handshake_msg_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx),
  .tx_bit_valid(tx_bit_valid), .tx_bit_ready(tx_bit_ready), .tx_bit(tx_bit),
  .rx_byte_valid(rx_byte_valid), .rx_msg_end(rx_msg_end)
);

// File: tb/handshake_msg_framer_tb.sv
module handshake_msg_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 0, rst_n = 0;
  logic tx_valid = 0, tx_last = 0, tx_reply = 0;
  logic [7:0] tx_data = '0;
  logic tx_ready, tx_bit_valid, tx_bit, tx_bit_ready;
  logic rx_bit_valid = 0, rx_bit = 0;
  logic rx_byte_valid, rx_msg_end, dir_tx;
  logic [7:0] rx_byte;

  int checks = 0, fails = 0, cyc = 0;
  bit exp_bits[$];
  string exp_tags[$];
  logic [8:0] exp_rx[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  handshake_msg_framer u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_reply(tx_reply),
    .tx_bit_valid(tx_bit_valid), .tx_bit_ready(tx_bit_ready), .tx_bit(tx_bit),
    .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
    .rx_msg_end(rx_msg_end), .dir_tx(dir_tx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    chk(exp_bits.size() == 0, "R3 pending tx bits", exp_bits.size(), 0);
    chk(exp_rx.size() == 0, "R6 pending rx items", exp_rx.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Link ready pattern and tx bit monitor (one process owns both).
  initial tx_bit_ready = 1'b1;
  always @(negedge clk) begin
    cyc++;
    tx_bit_ready = (cyc % 4) != 2;
    if (rst_n && tx_bit_valid && tx_bit_ready) begin
      if (exp_bits.size() == 0) begin
        chk(0, "R10 unexpected tx bit", tx_bit, 0);
      end else begin
        bit e; string t;
        e = exp_bits.pop_front();
        t = exp_tags.pop_front();
        chk(tx_bit == e, t, tx_bit, e);
      end
    end
    if (rst_n && rx_byte_valid) begin
      if (exp_rx.size() == 0) chk(0, "R6 unexpected byte", rx_byte, 0);
      else begin
        logic [8:0] e;
        e = exp_rx.pop_front();
        chk({1'b0, rx_byte} == e, "R6 rx byte", rx_byte, e);
      end
    end
    if (rst_n && rx_msg_end) begin
      if (exp_rx.size() == 0) chk(0, "R7 unexpected end", 9'h100, 0);
      else begin
        logic [8:0] e;
        e = exp_rx.pop_front();
        chk(e == 9'h100, "R7 rx end", 9'h100, e);
      end
    end
    if (cyc > WATCHDOG) begin
      chk(0, "watchdog", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic push_byte_bits(input logic [7:0] b);
    exp_bits.push_back(1'b0); exp_tags.push_back("R2 start bit");
    for (int i = 7; i >= 0; i--) begin
      exp_bits.push_back(b[i]); exp_tags.push_back("R2 R5 data bit");
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit last, input bit reply);
    @(negedge clk);
    tx_valid = 1; tx_data = b; tx_last = last; tx_reply = reply;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_tx_done();
    while (dir_tx || exp_bits.size() != 0) @(negedge clk);
  endtask

  task automatic rx_send(input bit b);
    @(negedge clk);
    rx_bit_valid = 1; rx_bit = b;
    @(negedge clk);
    rx_bit_valid = 0;
  endtask

  task automatic rx_send_byte(input logic [7:0] b);
    rx_send(1'b0);
    for (int i = 7; i >= 0; i--) rx_send(b[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(dir_tx == 0, "R11 dir_tx", dir_tx, 0);
    chk(tx_ready == 1, "R11 tx_ready", tx_ready, 1);
    chk(tx_bit_valid == 0, "R11 tx_bit_valid", tx_bit_valid, 0);
    chk(rx_byte_valid == 0 && rx_msg_end == 0, "R11 rx outputs", rx_byte_valid, 0);

    // Two-byte message, no reply, with a pause between bytes
    exp_bits.push_back(1'b1); exp_tags.push_back("R1 lead one");
    push_byte_bits(8'hA5);
    push_byte_bits(8'h3C);
    exp_bits.push_back(1'b1); exp_tags.push_back("R3 end one");
    send_byte(8'hA5, 0, 0);
    chk(dir_tx == 1, "R10 dir after accept", dir_tx, 1);
    while (!tx_ready) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk(tx_bit_valid == 0, "R4 idle between bytes", tx_bit_valid, 0);
      chk(dir_tx == 1, "R4 R10 dir held", dir_tx, 1);
      chk(tx_ready == 1, "R4 ready between bytes", tx_ready, 1);
      @(negedge clk);
    end
    send_byte(8'h3C, 1, 0);
    wait_tx_done();
    chk(dir_tx == 0, "R3 dir back to rx", dir_tx, 0);
    chk(tx_ready == 1, "R8 no reply: ready again", tx_ready, 1);

    // One-byte message expecting a reply
    exp_bits.push_back(1'b1); exp_tags.push_back("R1 lead one");
    push_byte_bits(8'h81);
    exp_bits.push_back(1'b1); exp_tags.push_back("R3 end one");
    send_byte(8'h81, 1, 1);
    wait_tx_done();
    chk(tx_ready == 0, "R8 waiting for reply", tx_ready, 0);
    repeat (4) @(negedge clk);
    chk(tx_ready == 0, "R8 still waiting", tx_ready, 0);

    // Incoming reply: filler ones, two bytes, end marker, trailing ones
    exp_rx.push_back(9'h05A);
    exp_rx.push_back(9'h0FF);
    exp_rx.push_back(9'h100);
    rx_send(1'b1); rx_send(1'b1);
    chk(tx_ready == 0, "R8 fillers do not release", tx_ready, 0);
    rx_send_byte(8'h5A);
    rx_send_byte(8'hFF);
    rx_send(1'b1);
    @(negedge clk);
    chk(tx_ready == 1, "R8 released by rx end", tx_ready, 1);
    rx_send(1'b1); rx_send(1'b1);
    repeat (3) @(negedge clk);
    chk(exp_rx.size() == 0, "R7 trailing ones ignored", exp_rx.size(), 0);

    // Incoming message while idle blocks sending (R9)
    exp_rx.push_back(9'h000);
    exp_rx.push_back(9'h100);
    rx_send(1'b0); rx_send(1'b0); rx_send(1'b0);
    chk(tx_ready == 0, "R9 busy mid byte", tx_ready, 0);
    for (int i = 0; i < 6; i++) rx_send(1'b0);
    chk(tx_ready == 0, "R9 busy after byte", tx_ready, 0);
    rx_send(1'b1);
    @(negedge clk);
    chk(tx_ready == 1, "R9 free after end", tx_ready, 1);

    // Another message after receive, value 0x00 then 0xFF
    exp_bits.push_back(1'b1); exp_tags.push_back("R1 lead one");
    push_byte_bits(8'h00);
    push_byte_bits(8'hFF);
    exp_bits.push_back(1'b1); exp_tags.push_back("R3 end one");
    send_byte(8'h00, 0, 0);
    send_byte(8'hFF, 1, 0);
    wait_tx_done();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule